// File: doc/BRIEF.md
# Register-Offset Load Address Generator

This block takes one word-load instruction that forms its address from a base register and an index register. It decodes the instruction and reads both register values through a combinational register-file read port. It shifts the index value and computes the offset address. It then chooses the access address and produces the controls that the core around it needs: a writeback of the updated base, the destination register, a load-to-program-counter request, and flags for foreign, literal and unpredictable encodings.

The instruction can arrive in one of three forms, chosen by a mode input:
- a 32-bit fixed-width form, which selects offset, pre-indexed or post-indexed addressing, chooses add or subtract, and applies a shift to the index;
- a 16-bit compact form, carried in the low half of the input word;
- a 32-bit compact form.

Both compact forms always add the index to the base and never write back.

Instructions arrive on a valid/ready input. The result leaves one cycle later on a valid/ready output through a single register stage. The input is ready when the output stage is empty or is being drained in the same cycle. While the output is valid and not accepted, the output holds its contents unchanged and the input is not ready. There is no other buffering.

Top module: `regoff_load_agen`

## Requirements
- R1: Fixed-width form (`in_mode`=00) decoding:
  - The instruction is accepted as this load only when all of the following hold: bits [31:28] are not 1111, bits [27:25] are 011, bit 22 is 0, bit 20 is 1, bit 4 is 0, and bits {24,21} are not {0,1}.
  - Otherwise, and also for `in_mode`=11, `out_not_mine` is 1 and `out_wb_en`, `out_pc_load` and `out_unpred` are 0.
- R2: Fixed-width addressing is selected by bits {24,21}:
  - 10 (offset): address = offset address, with no writeback.
  - 11 (pre-indexed): address = offset address, and the offset address is written back.
  - 00 (post-indexed): address = unmodified base, and the offset address is written back.
  - On writeback, `out_wb_sel` is the base field [19:16] and `out_wb_val` is the offset address.
- R3: In the fixed-width form, bit 23 = 1 adds the shifted index to the base, and bit 23 = 0 subtracts it. Fields: base [19:16], destination [15:12], index [3:0].
- R4: The fixed-width index shift uses kind [6:5] and amount [11:7]:
  - 00: shift left.
  - 01: logical right shift; an amount of 0 gives zero.
  - 10: arithmetic right shift; an amount of 0 fills every bit with the sign bit.
  - 11: rotate right; an amount of 0 is a one-bit rotate in which `in_carry` enters the top bit.
- R5: 16-bit compact form (`in_mode`=01):
  - Bits [15:9] must be 0101100; otherwise the instruction is foreign.
  - Fields: index [8:6], base [5:3], destination [2:0], each zero-extended to 4 bits.
  - The address is base + index, unshifted, and there is no writeback.
- R6: 32-bit compact form (`in_mode`=10):
  - Bits [31:20] must be 111110000101 and bits [11:6] must be zero; otherwise the instruction is foreign.
  - Fields: base [19:16], destination [15:12], left-shift amount [5:4], index [3:0].
  - The address is base + (index << amount), and there is no writeback.
  - A base field of 1111 sets `out_literal`, with `out_wb_en`, `out_pc_load` and `out_unpred` all 0.
- R7: `out_unpred` is 1 for an accepted instruction in any of these cases:
  - the index field is 15;
  - in the fixed-width form, writeback is on and the base field is 15 or equals the destination field;
  - in the 32-bit compact form, the destination is 15, `in_cond_block` is 1 and `in_cond_last` is 0.
- R8: With a destination of 15, an address whose bits [1:0] are not 00 sets `out_unpred`. `out_pc_load` is 1 exactly when the destination is 15, the instruction is accepted, bits [1:0] are 00 and `out_unpred` is 0.
- R9: Handshake:
  - `in_ready` = not `out_valid`, or `out_ready`.
  - An accepted instruction appears on the outputs at the next clock edge.
  - While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R10: While `rst_n` is low, `out_valid` is 0. After reset, `in_ready` is 1.
- R11: `rf_base_sel` and `rf_index_sel` show, combinationally, the decoded base and index fields of `in_insn` for the current `in_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_mode | input | 2 | Encoding form: 00 fixed, 01 compact 16-bit, 10 compact 32-bit |
| in_insn | input | 32 | Instruction word (the 16-bit form in [15:0]) |
| in_carry | input | 1 | Carry-in for the one-bit rotate |
| in_cond_block | input | 1 | Instruction is inside a conditional block |
| in_cond_last | input | 1 | Instruction is the last of that block |
| rf_base_sel | output | 4 | Register-file read select, base |
| rf_index_sel | output | 4 | Register-file read select, index |
| rf_base_val | input | DATA_W | Base register value |
| rf_index_val | input | DATA_W | Index register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | DATA_W | Memory access address |
| out_wb_en | output | 1 | Write the offset address back to the base register |
| out_wb_sel | output | 4 | Writeback register |
| out_wb_val | output | DATA_W | Writeback value (offset address) |
| out_dest | output | 4 | Destination register of the loaded word |
| out_pc_load | output | 1 | Loaded word becomes the program counter |
| out_unpred | output | 1 | Unpredictable encoding |
| out_not_mine | output | 1 | Not this instruction |
| out_literal | output | 1 | Route to the literal-load path |

## Verification
The assertions watch the output stage on every cycle:
- the stage holds its contents under back-pressure and fills on the edge after acceptance;
- a program-counter load is always word-aligned and never unpredictable;
- foreign and literal results never request a writeback or a branch;
- the 16-bit form never writes back.

The arithmetic can only be shown by the bench's directed scenarios:
- the address values;
- the four shift kinds and their zero-amount special cases;
- the add/subtract and indexing choices;
- each individual cause of the unpredictable flag.

// File: rtl/regoff_load_agen_pkg.sv
package regoff_load_agen_pkg;

  localparam int SEL_W = 4;
  localparam int AMT_W = 5;

  typedef enum logic [1:0] {
    ENC_FIXED  = 2'b00,
    ENC_NARROW = 2'b01,
    ENC_WIDE   = 2'b10,
    ENC_RSVD   = 2'b11
  } enc_mode_e;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic [SEL_W-1:0] base_sel;
    logic [SEL_W-1:0] index_sel;
    logic [SEL_W-1:0] dest_sel;
    shift_kind_e      kind;
    logic [AMT_W-1:0] amount;
    logic             pre_index;
    logic             add;
    logic             wb;
    logic             foreign;
    logic             literal;
    logic             fixed_form;
    logic             wide_form;
  } dec_t;

endpackage

// File: rtl/regoff_load_decode.sv
module regoff_load_decode
  import regoff_load_agen_pkg::*;
(
  input  logic [1:0]  mode,
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic fixed_match, narrow_match, wide_match;

  always_comb begin
    fixed_match  = (insn[31:28] != 4'hF) && (insn[27:25] == 3'b011) &&
                   !insn[22] && insn[20] && !insn[4];
    narrow_match = (insn[15:9] == 7'b0101100);
    wide_match   = (insn[31:20] == 12'b1111_1000_0101) && (insn[11:6] == 6'b0);

    dec = '0;
    dec.kind = SK_LSL;
    unique case (enc_mode_e'(mode))
      ENC_FIXED: begin
        dec.fixed_form = 1'b1;
        dec.base_sel   = insn[19:16];
        dec.dest_sel   = insn[15:12];
        dec.index_sel  = insn[3:0];
        dec.amount     = insn[11:7];
        dec.kind       = shift_kind_e'(insn[6:5]);
        dec.pre_index  = insn[24];
        dec.add        = insn[23];
        dec.wb         = !insn[24] || insn[21];
        dec.foreign    = !fixed_match || (!insn[24] && insn[21]);
      end
      ENC_NARROW: begin
        dec.base_sel   = {1'b0, insn[5:3]};
        dec.dest_sel   = {1'b0, insn[2:0]};
        dec.index_sel  = {1'b0, insn[8:6]};
        dec.pre_index  = 1'b1;
        dec.add        = 1'b1;
        dec.foreign    = !narrow_match;
      end
      ENC_WIDE: begin
        dec.wide_form  = 1'b1;
        dec.base_sel   = insn[19:16];
        dec.dest_sel   = insn[15:12];
        dec.index_sel  = insn[3:0];
        dec.amount     = {3'b000, insn[5:4]};
        dec.pre_index  = 1'b1;
        dec.add        = 1'b1;
        dec.foreign    = !wide_match;
        dec.literal    = wide_match && (insn[19:16] == 4'hF);
      end
      default: begin
        dec.foreign    = 1'b1;
      end
    endcase
    // no writeback for any instruction that is not handled here
    if (dec.foreign || dec.literal) dec.wb = 1'b0;
  end

endmodule

// File: rtl/regoff_load_shift.sv
module regoff_load_shift
  import regoff_load_agen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result
);

  localparam int BACK_W = AMT_W + 3;

  logic [BACK_W-1:0] back;

  always_comb begin
    back = BACK_W'(DATA_W) - BACK_W'(amount);
    unique case (kind)
      SK_LSL: result = value << amount;
      SK_LSR: result = (amount == '0) ? '0 : (value >> amount);
      SK_ASR: result = (amount == '0) ? {DATA_W{value[DATA_W-1]}}
                                      : $unsigned($signed(value) >>> amount);
      default: result = (amount == '0) ? {carry_in, value[DATA_W-1:1]}
                                       : ((value >> amount) | (value << back));
    endcase
  end

endmodule

// File: rtl/regoff_load_addr.sv
module regoff_load_addr #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              add,
  input  logic              pre_index,
  output logic [DATA_W-1:0] offset_addr,
  output logic [DATA_W-1:0] access_addr
);

  always_comb begin
    offset_addr = add ? (base + offset) : (base - offset);
    access_addr = pre_index ? offset_addr : base;
  end

endmodule

// File: rtl/regoff_load_agen.sv
module regoff_load_agen
  import regoff_load_agen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [31:0]       in_insn,
  input  logic              in_carry,
  input  logic              in_cond_block,
  input  logic              in_cond_last,
  output logic [SEL_W-1:0]  rf_base_sel,
  output logic [SEL_W-1:0]  rf_index_sel,
  input  logic [DATA_W-1:0] rf_base_val,
  input  logic [DATA_W-1:0] rf_index_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_addr,
  output logic              out_wb_en,
  output logic [SEL_W-1:0]  out_wb_sel,
  output logic [DATA_W-1:0] out_wb_val,
  output logic [SEL_W-1:0]  out_dest,
  output logic              out_pc_load,
  output logic              out_unpred,
  output logic              out_not_mine,
  output logic              out_literal
);

  localparam logic [SEL_W-1:0] PC_SEL = {SEL_W{1'b1}};

  dec_t              dec;
  logic [DATA_W-1:0] offset, offset_addr, access_addr;
  logic              accepted, dest_pc, aligned, unpred, pc_load;

  regoff_load_decode u_decode (
    .mode (in_mode),
    .insn (in_insn),
    .dec  (dec)
  );

  assign rf_base_sel  = dec.base_sel;
  assign rf_index_sel = dec.index_sel;

  regoff_load_shift #(.DATA_W(DATA_W)) u_shift (
    .value    (rf_index_val),
    .kind     (dec.kind),
    .amount   (dec.amount),
    .carry_in (in_carry),
    .result   (offset)
  );

  regoff_load_addr #(.DATA_W(DATA_W)) u_addr (
    .base        (rf_base_val),
    .offset      (offset),
    .add         (dec.add),
    .pre_index   (dec.pre_index),
    .offset_addr (offset_addr),
    .access_addr (access_addr)
  );

  always_comb begin
    accepted = !dec.foreign && !dec.literal;
    dest_pc  = (dec.dest_sel == PC_SEL);
    aligned  = (access_addr[1:0] == 2'b00);
    unpred   = accepted && (
                 (dec.index_sel == PC_SEL) ||
                 (dec.fixed_form && dec.wb &&
                  ((dec.base_sel == PC_SEL) || (dec.base_sel == dec.dest_sel))) ||
                 (dec.wide_form && dest_pc && in_cond_block && !in_cond_last) ||
                 (dest_pc && !aligned));
    pc_load  = accepted && dest_pc && aligned && !unpred;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_wb_en    <= 1'b0;
      out_wb_sel   <= '0;
      out_wb_val   <= '0;
      out_dest     <= '0;
      out_pc_load  <= 1'b0;
      out_unpred   <= 1'b0;
      out_not_mine <= 1'b0;
      out_literal  <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid    <= 1'b1;
      out_addr     <= access_addr;
      out_wb_en    <= dec.wb;
      out_wb_sel   <= dec.base_sel;
      out_wb_val   <= offset_addr;
      out_dest     <= dec.dest_sel;
      out_pc_load  <= pc_load;
      out_unpred   <= unpred;
      out_not_mine <= dec.foreign;
      out_literal  <= dec.literal;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // R9: a stalled result keeps every field
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_wb_val) &&
      $stable(out_wb_en) && $stable(out_dest) && $stable(out_unpred));

  // R9: an accepted instruction is presented on the next edge
  a_r9_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: a program-counter load is aligned and clean
  a_r8_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pc_load |-> out_addr[1:0] == 2'b00 && out_dest == PC_SEL && !out_unpred);

  // R1: a foreign word requests nothing
  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_not_mine |-> !out_wb_en && !out_pc_load && !out_unpred);

  // R6: a literal-path word requests nothing
  a_r6_literal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_literal |-> !out_wb_en && !out_pc_load && !out_unpred);

  // R5: the 16-bit form never writes back
  a_r5_narrow_nowb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == ENC_NARROW |=> !out_wb_en);

endmodule

// File: tb/test_regoff_load_agen.sv
`timescale 1ns/1ps
module test_regoff_load_agen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic [31:0] in_insn = '0;
  logic        in_carry = 1'b0;
  logic        in_cond_block = 1'b0;
  logic        in_cond_last = 1'b0;
  logic [3:0]  rf_base_sel, rf_index_sel;
  logic [31:0] rf_base_val, rf_index_val;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr, out_wb_val;
  logic        out_wb_en, out_pc_load, out_unpred, out_not_mine, out_literal;
  logic [3:0]  out_wb_sel, out_dest;

  logic [31:0] regs [16];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign rf_base_val  = regs[rf_base_sel];
  assign rf_index_val = regs[rf_index_sel];

  regoff_load_agen i_regoff_load_agen (
    .clk, .rst_n, .in_valid, .in_ready, .in_mode, .in_insn, .in_carry,
    .in_cond_block, .in_cond_last, .rf_base_sel, .rf_index_sel,
    .rf_base_val, .rf_index_val, .out_valid, .out_ready, .out_addr,
    .out_wb_en, .out_wb_sel, .out_wb_val, .out_dest, .out_pc_load,
    .out_unpred, .out_not_mine, .out_literal
  );

  function automatic logic [31:0] fx(input logic [3:0] c, input logic p, u, w,
                                     input logic [3:0] b, d, input logic [4:0] a,
                                     input logic [1:0] k, input logic [3:0] x);
    return {c, 3'b011, p, u, 1'b0, w, 1'b1, b, d, a, k, 1'b0, x};
  endfunction

  function automatic logic [31:0] nw(input logic [2:0] x, b, d);
    return {16'h0, 7'b0101100, x, b, d};
  endfunction

  function automatic logic [31:0] wd(input logic [3:0] b, d, input logic [1:0] s,
                                     input logic [3:0] x);
    return {12'b1111_1000_0101, b, d, 6'b0, s, x};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [31:0] w,
                       input logic cy = 1'b0, input logic cb = 1'b0, input logic cl = 1'b0);
    @(negedge clk);
    in_mode = m; in_insn = w; in_carry = cy; in_cond_block = cb; in_cond_last = cl;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 valid in reset", 32'(out_valid), 0);
    chk("R10 ready after reset", 32'(in_ready), 1);
  endtask

  task automatic t_fixed_modes;
    regs[1] = 32'h1000; regs[2] = 32'h10;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd2, 2'b00, 4'd2));
    chk("R2 offset addr", out_addr, 32'h1040);
    chk("R2 offset no wb", 32'(out_wb_en), 0);
    chk("R3 dest field", 32'(out_dest), 3);
    chk("R9 valid after accept", 32'(out_valid), 1);
    regs[4] = 32'h2000; regs[5] = 32'h100;
    issue(2'b00, fx(4'hE, 1, 0, 1, 4'd4, 4'd6, 5'd4, 2'b01, 4'd5));
    chk("R3 pre subtract addr", out_addr, 32'h1FF0);
    chk("R2 pre wb en", 32'(out_wb_en), 1);
    chk("R2 pre wb sel", 32'(out_wb_sel), 4);
    chk("R2 pre wb val", out_wb_val, 32'h1FF0);
    regs[7] = 32'h3000; regs[8] = 32'h8000_0000;
    issue(2'b00, fx(4'hE, 0, 1, 0, 4'd7, 4'd9, 5'd0, 2'b10, 4'd8));
    chk("R2 post addr is base", out_addr, 32'h3000);
    chk("R2 post wb val", out_wb_val, 32'h2FFF);
    chk("R2 post wb en", 32'(out_wb_en), 1);
  endtask

  task automatic t_shifts;
    regs[1] = 32'h1000; regs[2] = 32'h3;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b11, 4'd2), 1'b1);
    chk("R4 rotate carry 1", out_addr, 32'h8000_1001);
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b11, 4'd2), 1'b0);
    chk("R4 rotate carry 0", out_addr, 32'h0000_1001);
    regs[2] = 32'h1234_5678;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd8, 2'b11, 4'd2));
    chk("R4 rotate by 8", out_addr, 32'h7812_4456);
    regs[2] = 32'hFFFF_FFFF;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b01, 4'd2));
    chk("R4 logical right 0 gives zero", out_addr, 32'h1000);
    regs[2] = 32'h8000_0000;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd4, 2'b10, 4'd2));
    chk("R4 arithmetic right 4", out_addr, 32'hF800_1000);
    regs[2] = 32'h1;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd31, 2'b00, 4'd2));
    chk("R4 left 31", out_addr, 32'h8000_1000);
  endtask

  task automatic t_foreign;
    issue(2'b00, fx(4'hE, 0, 1, 1, 4'd1, 4'd3, 5'd0, 2'b00, 4'd2));
    chk("R1 unprivileged form flagged", 32'(out_not_mine), 1);
    chk("R1 unprivileged form no wb", 32'(out_wb_en), 0);
    issue(2'b00, fx(4'hF, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b00, 4'd2));
    chk("R1 cond 1111 flagged", 32'(out_not_mine), 1);
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b00, 4'd2) | 32'h10);
    chk("R1 bit4 set flagged", 32'(out_not_mine), 1);
    issue(2'b11, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b00, 4'd2));
    chk("R1 reserved mode flagged", 32'(out_not_mine), 1);
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b00, 4'd2));
    chk("R1 legal word accepted", 32'(out_not_mine), 0);
  endtask

  task automatic t_unpred;
    regs[3] = 32'h500; regs[2] = 32'h4;
    issue(2'b00, fx(4'hE, 1, 1, 1, 4'd3, 4'd3, 5'd0, 2'b00, 4'd2));
    chk("R7 wb base equals dest", 32'(out_unpred), 1);
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd3, 4'd3, 5'd0, 2'b00, 4'd2));
    chk("R7 no wb base equals dest ok", 32'(out_unpred), 0);
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd3, 4'd4, 5'd0, 2'b00, 4'd15));
    chk("R7 index 15", 32'(out_unpred), 1);
    issue(2'b00, fx(4'hE, 0, 1, 0, 4'd15, 4'd4, 5'd0, 2'b00, 4'd2));
    chk("R7 wb base 15", 32'(out_unpred), 1);
  endtask

  task automatic t_narrow;
    regs[4] = 32'h400; regs[5] = 32'h24;
    @(negedge clk);
    in_mode = 2'b01; in_insn = nw(3'd5, 3'd4, 3'd2);
    #1;
    chk("R11 base select", 32'(rf_base_sel), 4);
    chk("R11 index select", 32'(rf_index_sel), 5);
    issue(2'b01, nw(3'd5, 3'd4, 3'd2));
    chk("R5 narrow addr", out_addr, 32'h424);
    chk("R5 narrow dest", 32'(out_dest), 2);
    chk("R5 narrow no wb", 32'(out_wb_en), 0);
    issue(2'b01, nw(3'd5, 3'd4, 3'd2) ^ 32'h200);
    chk("R5 narrow bad opcode", 32'(out_not_mine), 1);
  endtask

  task automatic t_wide;
    regs[1] = 32'h1000; regs[2] = 32'h10;
    issue(2'b10, wd(4'd1, 4'd3, 2'd3, 4'd2));
    chk("R6 wide shifted addr", out_addr, 32'h1080);
    chk("R6 wide no wb", 32'(out_wb_en), 0);
    chk("R6 wide not literal", 32'(out_literal), 0);
    issue(2'b10, wd(4'd15, 4'd3, 2'd0, 4'd2));
    chk("R6 literal flag", 32'(out_literal), 1);
    chk("R6 literal no unpred", 32'(out_unpred), 0);
    chk("R6 literal not foreign", 32'(out_not_mine), 0);
    issue(2'b10, wd(4'd1, 4'd15, 2'd0, 4'd2), 1'b0, 1'b1, 1'b0);
    chk("R7 pc dest mid cond block", 32'(out_unpred), 1);
    chk("R8 no pc load mid block", 32'(out_pc_load), 0);
    issue(2'b10, wd(4'd1, 4'd15, 2'd0, 4'd2), 1'b0, 1'b1, 1'b1);
    chk("R8 pc load last in block", 32'(out_pc_load), 1);
    chk("R7 last in block clean", 32'(out_unpred), 0);
    issue(2'b10, wd(4'd1, 4'd3, 2'd0, 4'd15));
    chk("R7 wide index 15", 32'(out_unpred), 1);
  endtask

  task automatic t_pc_load;
    regs[1] = 32'h1000; regs[2] = 32'h10;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd15, 5'd0, 2'b00, 4'd2));
    chk("R8 aligned pc load", 32'(out_pc_load), 1);
    regs[2] = 32'h11;
    issue(2'b00, fx(4'hE, 1, 1, 0, 4'd1, 4'd15, 5'd0, 2'b00, 4'd2));
    chk("R8 misaligned unpred", 32'(out_unpred), 1);
    chk("R8 misaligned no pc load", 32'(out_pc_load), 0);
    regs[1] = 32'h1002; regs[2] = 32'h0;
    issue(2'b00, fx(4'hE, 0, 1, 0, 4'd1, 4'd15, 5'd0, 2'b00, 4'd2));
    chk("R8 post base misaligned", 32'(out_unpred), 1);
  endtask

  task automatic t_backpressure;
    regs[1] = 32'h1000; regs[2] = 32'h10;
    @(negedge clk);
    in_mode = 2'b00; in_insn = fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd0, 2'b00, 4'd2);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_insn = fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 5'd1, 2'b00, 4'd2);
    chk("R9 stalled not ready", 32'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 held addr", out_addr, 32'h1010);
    chk("R9 held valid", 32'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result", out_addr, 32'h1020);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears valid", 32'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed_modes();
    t_shifts();
    t_foreign();
    t_unpred();
    t_narrow();
    t_wide();
    t_pc_load();
    t_backpressure();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule